// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block is a 32-line general-purpose I/O controller. Software reaches it through a small memory-mapped register port that uses whole 32-bit words. Each line can be set as an input or an output. Output lines drive their pad from a written data value. Input lines pass through a two-stage synchronizer. The block then reports their level through the data register, but only for lines whose input buffer is enabled.

The synchronized level of every line goes to an edge detector. A per-line edge-select bit picks one of two modes: the line flags falling edges only, or it flags both rising and falling edges. A qualifying edge sets a sticky pending bit, and software clears that bit by writing a one to it. A mask register picks which pending bits may drive the single interrupt output. The interrupt output is a registered level.

Line n always sits at register bit 31-n. Line 0 therefore lives in the most significant bit of every register, while the pad buses are indexed by line number. Register map by byte offset:

| Offset | Register |
|---|---|
| 0x00 | direction |
| 0x04 | open-drain select (stored only) |
| 0x08 | data |
| 0x0C | pending events |
| 0x10 | interrupt mask |
| 0x14 | edge select |
| 0x1C | input buffer enable |

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, except the input buffer enable register, which reads 0xFFFFFFFF. After reset, pad_oe is all zero and irq is 0.
- R2: Line n corresponds to bit 31-n of every register. pad_in, pad_out and pad_oe are indexed by line number n.
- R3: A direction bit of 1 makes the line an output: pad_oe[n] equals direction bit 31-n. pad_out[n] always equals data register bit 31-n. A write takes effect at the clock edge that accepts it.
- R4: For an input line, the data register read returns the synchronized pad value when the line's input buffer enable bit is 1. It returns 0 when that bit is 0.
- R5: For an output line, the data register read returns the value last written to it, not the pad value.
- R6: A pad change on an input line becomes visible in the data read after exactly two rising clock edges.
- R7: Edge-select bit 1 makes the line flag falling edges only. Edge-select bit 0 makes it flag both rising and falling edges. A pad change sets the pending bit at the third rising edge after the change.
- R8: The pending register is write-one-to-clear. A written 1 clears that bit, and a written 0 leaves it unchanged.
- R9: Pending bits are set whether or not the line is masked. irq is 1 in the cycle after any bit of (pending AND mask) is 1, and 0 in the cycle after none is.
- R10: When a qualifying edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R11: The open-drain register stores and returns what is written without affecting pad_oe or pad_out. An unmapped offset (0x18) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while bus_sel is 1, else 0 |
| pad_in | input | 32 | Pad input levels, indexed by line |
| pad_out | output | 32 | Pad output values, indexed by line |
| pad_oe | output | 32 | Pad output enables, indexed by line |
| irq | output | 1 | Combined registered interrupt level |

## Verification
The edge logic is driven with rising and falling pad transitions on two lines that share timing but use different edge-select values. This separates falling-only events from both-edge events and exposes a swapped select polarity. Readback is tried with output lines whose pad is held opposite to the written value, and with input lines whose buffer enable is switched off. This shows whether the read path selects the written value, the pad or a masked zero. Single-cycle samples around the second and third clock edges pin down the synchronizer depth and the event latency. A clearing write placed in the same cycle as an event arrival tests the priority between the two.

// File: rtl/gpio_ec_pkg.sv
package gpio_ec_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_DIR = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_ODR = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_EVT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_MSK = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_EDG = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_IBE = 5'h1C;

  typedef enum logic [2:0] {
    RS_DIR, RS_ODR, RS_DAT, RS_EVT, RS_MSK, RS_EDG, RS_IBE, RS_NONE
  } regsel_e;

  function automatic regsel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_DIR: return RS_DIR;
      OFF_ODR: return RS_ODR;
      OFF_DAT: return RS_DAT;
      OFF_EVT: return RS_EVT;
      OFF_MSK: return RS_MSK;
      OFF_EDG: return RS_EDG;
      OFF_IBE: return RS_IBE;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_ec_regs.sv
module gpio_ec_regs
  import gpio_ec_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  regsel_e           wr_sel,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] dir_q,
  output logic [NLINES-1:0] odr_q,
  output logic [NLINES-1:0] dat_q,
  output logic [NLINES-1:0] msk_q,
  output logic [NLINES-1:0] edg_q,
  output logic [NLINES-1:0] ibe_q
);

  logic [NLINES-1:0] dir_d, odr_d, dat_d, msk_d, edg_d, ibe_d;

  always_comb begin
    dir_d = dir_q;
    odr_d = odr_q;
    dat_d = dat_q;
    msk_d = msk_q;
    edg_d = edg_q;
    ibe_d = ibe_q;
    if (wr_en) begin
      case (wr_sel)
        RS_DIR:  dir_d = wdata;
        RS_ODR:  odr_d = wdata;
        RS_DAT:  dat_d = wdata;
        RS_MSK:  msk_d = wdata;
        RS_EDG:  edg_d = wdata;
        RS_IBE:  ibe_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      edg_q <= '0;
      ibe_q <= '1;
    end else begin
      dir_q <= dir_d;
      odr_q <= odr_d;
      dat_q <= dat_d;
      msk_q <= msk_d;
      edg_q <= edg_d;
      ibe_q <= ibe_d;
    end
  end

  // R3: an accepted data write shows up in the stored value one edge later
  a_r3_dat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == RS_DAT) |=> (dat_q == $past(wdata)));

  // R11: a write to the open-drain register leaves direction untouched
  a_r11_odr_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == RS_ODR) |=> (dir_q == $past(dir_q)));

endmodule

// File: rtl/gpio_ec_capture.sv
module gpio_ec_capture #(
  parameter int NLINES      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] din,
  output logic [NLINES-1:0] sync_o,
  output logic [NLINES-1:0] rise_o,
  output logic [NLINES-1:0] fall_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NLINES-1:0] stg_q [SYNC_STAGES];
  logic [NLINES-1:0] stg_d [SYNC_STAGES];
  logic [NLINES-1:0] prev_q;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < SYNC_STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= stg_d[i];
      prev_q <= stg_q[LAST];
    end
  end

  assign sync_o = stg_q[LAST];
  assign rise_o = stg_q[LAST] & ~prev_q;
  assign fall_o = ~stg_q[LAST] & prev_q;

  // R7: a rise reported now means the synchronized level was low a cycle ago
  a_r7_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |-> ((rise_o & $past(sync_o)) == '0));

  // R7: a fall reported now means the synchronized level was high a cycle ago
  a_r7_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o != '0) |-> ((fall_o & ~$past(sync_o)) == '0));

endmodule

// File: rtl/gpio_ec_events.sv
module gpio_ec_events #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] rise,
  input  logic [NLINES-1:0] fall,
  input  logic [NLINES-1:0] edg_sel,
  input  logic [NLINES-1:0] clr,
  input  logic [NLINES-1:0] msk,
  output logic [NLINES-1:0] evt_q,
  output logic              irq_q
);

  logic [NLINES-1:0] qual;
  logic [NLINES-1:0] evt_d;
  logic              irq_d;

  always_comb begin
    qual  = fall | (rise & ~edg_sel);
    evt_d = (evt_q & ~clr) | qual;
    irq_d = |(evt_q & msk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq_q <= irq_d;
    end
  end

  // R10: a qualifying edge always leaves its bit set, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (qual != '0) |=> ((evt_q & $past(qual)) == $past(qual)));

  // R8: a cleared bit with no edge that cycle goes to zero
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~qual) != '0) |=> ((evt_q & $past(clr & ~qual)) == '0));

  // R8: no pending bit appears without a qualifying edge
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q) & ~$past(qual)) == '0));

  // R9: interrupt level follows pending AND mask one cycle later
  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_q & msk)) |=> irq_q);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(evt_q & msk)) |=> !irq_q);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ec_pkg::*;
#(
  parameter int NLINES      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq
);

  localparam int MSB = NLINES - 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_i_n;
  assign rst_i_n = rst_s2_q;

  regsel_e sel;
  logic    wr_fire;
  assign sel     = decode_addr(bus_addr);
  assign wr_fire = bus_sel & bus_we;

  logic [NLINES-1:0] dir_q, odr_q, dat_q, msk_q, edg_q, ibe_q;
  logic [NLINES-1:0] pin_bits, sync_bits, rise_bits, fall_bits;
  logic [NLINES-1:0] evt_q, clr_bits, dat_rd;

  // line n <-> register bit MSB-n
  for (genvar n = 0; n < NLINES; n++) begin : g_map
    assign pin_bits[MSB-n] = pad_in[n];
    assign pad_oe[n]       = dir_q[MSB-n];
    assign pad_out[n]      = dat_q[MSB-n];
  end

  gpio_ec_regs #(.NLINES(NLINES)) u_regs (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr_en (wr_fire),
    .wr_sel(sel),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .odr_q (odr_q),
    .dat_q (dat_q),
    .msk_q (msk_q),
    .edg_q (edg_q),
    .ibe_q (ibe_q)
  );

  gpio_ec_capture #(.NLINES(NLINES), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   (pin_bits),
    .sync_o(sync_bits),
    .rise_o(rise_bits),
    .fall_o(fall_bits)
  );

  assign clr_bits = (wr_fire && sel == RS_EVT) ? bus_wdata : '0;

  gpio_ec_events #(.NLINES(NLINES)) u_evt (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rise   (rise_bits),
    .fall   (fall_bits),
    .edg_sel(edg_q),
    .clr    (clr_bits),
    .msk    (msk_q),
    .evt_q  (evt_q),
    .irq_q  (irq)
  );

  assign dat_rd = (sync_bits & ~dir_q & ibe_q) | (dat_q & dir_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (sel)
        RS_DIR:  bus_rdata = dir_q;
        RS_ODR:  bus_rdata = odr_q;
        RS_DAT:  bus_rdata = dat_rd;
        RS_EVT:  bus_rdata = evt_q;
        RS_MSK:  bus_rdata = msk_q;
        RS_EDG:  bus_rdata = edg_q;
        RS_IBE:  bus_rdata = ibe_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R5: an output line's read-back bit tracks the stored data bit
  a_r5_out_readback: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && !bus_we && sel == RS_DAT) |-> ((bus_rdata & dir_q) == (dat_q & dir_q)));

  // R4: a disabled input buffer reads zero on input lines
  a_r4_ibe_gate: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && !bus_we && sel == RS_DAT) |-> ((bus_rdata & ~dir_q & ~ibe_q) == '0));

endmodule

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;

  localparam int N = 32;
  localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
                         A_EVT = 5'h0C, A_MSK = 5'h10, A_EDG = 5'h14,
                         A_GAP = 5'h18, A_IBE = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  gpio_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [N-1:0] lb(input int line);
    return {{(N-1){1'b0}}, 1'b1} << (N - 1 - line);
  endfunction

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [N-1:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    rd(A_DIR, v); chk("R1 dir", v, '0);
    rd(A_ODR, v); chk("R1 odr", v, '0);
    rd(A_DAT, v); chk("R1 dat", v, '0);
    rd(A_EVT, v); chk("R1 evt", v, '0);
    rd(A_MSK, v); chk("R1 msk", v, '0);
    rd(A_EDG, v); chk("R1 edg", v, '0);
    rd(A_IBE, v); chk("R1 ibe", v, '1);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 irq", {31'b0, irq}, '0);
    rd(A_GAP, v); chk("R11 gap read", v, '0);
  endtask

  task automatic t_outputs;
    logic [N-1:0] v;
    wr(A_DIR, lb(0) | lb(31));
    wr(A_DAT, lb(0));
    #1;
    chk("R2 R3 pad_oe", pad_oe, 32'h8000_0001);
    chk("R2 R3 pad_out", pad_out, 32'h0000_0001);
    pad_in[0] = 1'b0; pad_in[31] = 1'b1;
    repeat (4) @(posedge clk);
    rd(A_DAT, v);
    chk("R5 output readback", v, 32'h8000_0000);
    wr(A_DIR, '0);
    wr(A_DAT, '0);
    pad_in = '0;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_input_sync;
    logic [N-1:0] v;
    @(negedge clk);
    pad_in[5] = 1'b1;
    @(posedge clk); #2 peek(A_DAT, v);
    chk("R6 not yet after 1 edge", v, '0);
    @(posedge clk); #2 peek(A_DAT, v);
    chk("R6 visible after 2 edges", v, lb(5));
    wr(A_IBE, ~lb(5));
    rd(A_DAT, v);
    chk("R4 ibe off reads 0", v, '0);
    wr(A_IBE, '1);
    rd(A_DAT, v);
    chk("R4 ibe on reads pad", v, lb(5));
    pad_in[5] = 1'b0;
    repeat (4) @(posedge clk);
    wr(A_EVT, '1);
  endtask

  task automatic t_edges;
    logic [N-1:0] v;
    wr(A_EDG, lb(8));
    @(negedge clk);
    pad_in[7] = 1'b1; pad_in[8] = 1'b1;
    @(posedge clk); @(posedge clk); #2 peek(A_EVT, v);
    chk("R7 no event after 2 edges", v, '0);
    @(posedge clk); #2 peek(A_EVT, v);
    chk("R7 rise: both-edge line only", v, lb(7));
    chk("R9 masked event no irq", {31'b0, irq}, '0);
    wr(A_EVT, '1);
    @(negedge clk);
    pad_in[7] = 1'b0; pad_in[8] = 1'b0;
    repeat (4) @(posedge clk);
    rd(A_EVT, v);
    chk("R7 fall: both lines", v, lb(7) | lb(8));
    wr(A_EVT, '0);
    rd(A_EVT, v);
    chk("R8 zero write keeps", v, lb(7) | lb(8));
    wr(A_EVT, lb(7));
    rd(A_EVT, v);
    chk("R8 one write clears", v, lb(8));
  endtask

  task automatic t_irq;
    logic [N-1:0] v;
    wr(A_MSK, lb(3));
    @(posedge clk); #2;
    chk("R9 unmatched mask irq low", {31'b0, irq}, '0);
    wr(A_MSK, lb(8));
    @(posedge clk); #2;
    chk("R9 irq high", {31'b0, irq}, 32'd1);
    wr(A_EVT, lb(8));
    @(posedge clk); #2;
    chk("R9 irq low after clear", {31'b0, irq}, '0);
    rd(A_EVT, v);
    chk("R8 all clear", v, '0);
    wr(A_MSK, '0);
    wr(A_EDG, '0);
  endtask

  task automatic t_collision;
    logic [N-1:0] v;
    @(negedge clk);
    pad_in[9] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = A_EVT; bus_wdata = lb(9);
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
    rd(A_EVT, v);
    chk("R10 set wins over clear", v, lb(9));
    wr(A_EVT, lb(9));
    rd(A_EVT, v);
    chk("R8 later clear", v, '0);
  endtask

  task automatic t_odr;
    logic [N-1:0] v;
    wr(A_ODR, 32'hA5A5_0F0F);
    rd(A_ODR, v);
    chk("R11 odr readback", v, 32'hA5A5_0F0F);
    chk("R11 odr no pad_oe", pad_oe, '0);
    chk("R11 odr no pad_out", pad_out, '0);
    wr(A_GAP, 32'hFFFF_FFFF);
    rd(A_GAP, v);
    chk("R11 gap still 0", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_outputs();
    t_input_sync();
    t_edges();
    t_irq();
    t_collision();
    t_odr();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule